// File: doc/BRIEF.md
# D-PHY Clock Lane High-Speed Sequencer

This block drives the clock lane of a D-PHY transmitter between its low-power stop state and continuous high-speed clocking. When a link controller raises a high-speed request, the sequencer walks the lane through the low-power-to-high-speed entry steps. It raises an acknowledge once the clock has run long enough for the data lanes to start. When the request drops, it walks the lane back through the exit steps to stop. It can also park the lane in ultra-low-power state and wake it again.

Every interval is an 8-bit count of lane byte-clock cycles, where one byte-clock cycle is eight HS bit periods. The post interval is programmed as the clock-post time plus the HS trail time, rounded up. The block drives the lane's low-power and high-speed driver enables, the two low-power line levels, a flag that tells the analog side to toggle the HS clock, and a four-bit status field. Either driver enable can be forced from a control bit instead of the state machine. Analog drivers and clock generation sit outside this block. A controller must hold the high-speed request until the acknowledge is seen, or accept a short burst of clocking if it drops the request early.

Top module: `clk_lane_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, the lane is in stop: LP-11 (`lp_dp`=1, `lp_dn`=1), `tx_lp_en`=1, `tx_hs_en`=0, `hs_clk_run`=0, `hs_ack`=0, and status bit 2 set.
- R2: In stop, a sampled `hs_req` starts the entry: LP-01 (`lp_dp`=0, `lp_dn`=1, `tx_lp_en`=1) for `lpx_cyc` cycles, then LP-00 with `tx_lp_en`=1 for the prepare count, then HS-0 (`tx_hs_en`=1, `tx_lp_en`=0, `hs_clk_run`=0) for the zero count, then clocking (`tx_hs_en`=1, `hs_clk_run`=1) for `pre_cyc` cycles with `hs_ack`=0.
- R3: After the `pre_cyc` interval, if `hs_req` is high, clocking continues with `hs_ack`=1. It stays there for as long as `hs_req` stays high.
- R4: When `hs_req` is low in the acknowledged state, the exit starts: clocking with `hs_ack`=0 for the post count, then HS-0 for the trail count, then one or more cycles of stop.
- R5: A count of zero in any interval gives an interval of exactly one cycle. Any other value N gives N cycles.
- R6: `lane_tim` holds the prepare count in bits [31:24], the zero count in [23:16], the post count in [15:8] and the trail count in [7:0].
- R7: When `hs_ovr_sel`=1, `tx_hs_en` equals `hs_ovr_val`. When `lp_ovr_sel`=1, `tx_lp_en` equals `lp_ovr_val`. Each select works on its own enable only. Neither select changes the state sequence or the other outputs.
- R8: `lane_status` is {ready [3], stop [2], ultra-low-power [1], HS clock active [0]}. Bit 0 equals the state machine's `hs_clk_run`, whatever the overrides are set to.
- R9: In stop, with `hs_req` low, a sampled `ulps_req` drives LP-10 (`lp_dp`=1, `lp_dn`=0) for `lpx_cyc` cycles and then LP-00 with status bit 1 set. The lane stays there while `ulps_req` is high. Once `ulps_req` is low, it drives LP-10 for `lpx_cyc` cycles and then returns to stop. When both requests are high in stop, `hs_req` wins.
- R10: If `hs_req` is low when the `pre_cyc` interval ends, the lane goes straight to the exit sequence and `hs_ack` is never raised.
- R11: `lane_status[3]` shows `ana_ready` delayed by one clock and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_req | input | 1 | Request continuous HS clocking |
| ulps_req | input | 1 | Request ultra-low-power state |
| ana_ready | input | 1 | Analog bias ready, reported in status |
| lane_tim | input | 32 | Prepare, zero, post and trail counts |
| lpx_cyc | input | 8 | LP-01 / LP-10 interval count |
| pre_cyc | input | 8 | Clock cycles before the acknowledge |
| hs_ovr_sel | input | 1 | Take tx_hs_en from hs_ovr_val |
| hs_ovr_val | input | 1 | Forced tx_hs_en value |
| lp_ovr_sel | input | 1 | Take tx_lp_en from lp_ovr_val |
| lp_ovr_val | input | 1 | Forced tx_lp_en value |
| tx_hs_en | output | 1 | HS driver enable |
| tx_lp_en | output | 1 | LP driver enable |
| lp_dp | output | 1 | LP level, positive line |
| lp_dn | output | 1 | LP level, negative line |
| hs_clk_run | output | 1 | HS clock toggling |
| hs_ack | output | 1 | Clock lane ready for data HS |
| lane_status | output | 4 | {ready, stop, ulps, hs active} |

## Verification
All lane outputs decode the state register directly. A wrong state therefore shows on the line levels, enables or status in the cycle after the edge that produced it. A miscounted interval shows as a phase one cycle too long or too short, and the bench sees the difference at the next transition. A wrong choice between the hold, exit and ultra-low-power paths shows up at once as a different line pattern.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

    localparam int TIM_W = 8;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_LPX,
        ST_PREP,
        ST_HS_ZERO,
        ST_HS_PRE,
        ST_HS_RUN,
        ST_POST,
        ST_TRAIL,
        ST_ULPS_ENT,
        ST_ULPS,
        ST_ULPS_EXIT
    } lane_state_e;

    // Field order matches the bit positions of the timing word.
    typedef struct packed {
        logic [TIM_W-1:0] prep;
        logic [TIM_W-1:0] zero;
        logic [TIM_W-1:0] post;
        logic [TIM_W-1:0] trail;
    } lane_tim_t;

    typedef struct packed {
        logic lp_en;
        logic hs_en;
        logic dp;
        logic dn;
        logic clk_run;
        logic ack;
    } lane_drive_t;

    // Reload value for an interval: a zero count still lasts one cycle.
    function automatic logic [TIM_W-1:0] span_m1(input logic [TIM_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic lane_drive_t drive_of(input lane_state_e s);
        lane_drive_t d;
        d = '0;
        unique case (s)
            ST_STOP:      begin d.lp_en = 1'b1; d.dp = 1'b1; d.dn = 1'b1; end
            ST_LPX:       begin d.lp_en = 1'b1; d.dn = 1'b1; end
            ST_PREP:      d.lp_en = 1'b1;
            ST_HS_ZERO:   d.hs_en = 1'b1;
            ST_HS_PRE:    begin d.hs_en = 1'b1; d.clk_run = 1'b1; end
            ST_HS_RUN:    begin d.hs_en = 1'b1; d.clk_run = 1'b1; d.ack = 1'b1; end
            ST_POST:      begin d.hs_en = 1'b1; d.clk_run = 1'b1; end
            ST_TRAIL:     d.hs_en = 1'b1;
            ST_ULPS_ENT:  begin d.lp_en = 1'b1; d.dp = 1'b1; end
            ST_ULPS:      d.lp_en = 1'b1;
            ST_ULPS_EXIT: begin d.lp_en = 1'b1; d.dp = 1'b1; end
            default:      d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
    import clk_lane_pkg::*;
#(
    parameter int W = TIM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hs_req,
    input  logic         ulps_req,
    input  lane_tim_t    tim,
    input  logic [W-1:0] lpx_cyc,
    input  logic [W-1:0] pre_cyc,
    output lane_state_e  state,
    output lane_drive_t  drv
);
    lane_state_e  nxt;
    logic         ld;
    logic [W-1:0] ld_val;
    logic         t_done;

    clk_lane_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .done     (t_done)
    );

    always_comb begin
        nxt    = state;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state)
            ST_STOP: begin
                if (hs_req) begin
                    nxt = ST_LPX; ld = 1'b1; ld_val = span_m1(lpx_cyc);
                end else if (ulps_req) begin
                    nxt = ST_ULPS_ENT; ld = 1'b1; ld_val = span_m1(lpx_cyc);
                end
            end
            ST_LPX: if (t_done) begin
                nxt = ST_PREP; ld = 1'b1; ld_val = span_m1(tim.prep);
            end
            ST_PREP: if (t_done) begin
                nxt = ST_HS_ZERO; ld = 1'b1; ld_val = span_m1(tim.zero);
            end
            ST_HS_ZERO: if (t_done) begin
                nxt = ST_HS_PRE; ld = 1'b1; ld_val = span_m1(pre_cyc);
            end
            ST_HS_PRE: if (t_done) begin
                if (hs_req) begin
                    nxt = ST_HS_RUN;
                end else begin
                    nxt = ST_POST; ld = 1'b1; ld_val = span_m1(tim.post);
                end
            end
            ST_HS_RUN: if (!hs_req) begin
                nxt = ST_POST; ld = 1'b1; ld_val = span_m1(tim.post);
            end
            ST_POST: if (t_done) begin
                nxt = ST_TRAIL; ld = 1'b1; ld_val = span_m1(tim.trail);
            end
            ST_TRAIL:    if (t_done) nxt = ST_STOP;
            ST_ULPS_ENT: if (t_done) nxt = ST_ULPS;
            ST_ULPS: if (!ulps_req) begin
                nxt = ST_ULPS_EXIT; ld = 1'b1; ld_val = span_m1(lpx_cyc);
            end
            ST_ULPS_EXIT: if (t_done) nxt = ST_STOP;
            default: nxt = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_STOP;
        else     state <= nxt;
    end

    assign drv = drive_of(state);

    // R2
    prep_after_lpx_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PREP && $past(state) != ST_PREP) |-> ($past(state) == ST_LPX));

    // R3
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HS_RUN) |-> $past(hs_req));

    // R4
    trail_after_post_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRAIL && $past(state) != ST_TRAIL) |-> ($past(state) == ST_POST));

    // R9
    ulps_after_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ULPS && $past(state) != ST_ULPS) |-> ($past(state) == ST_ULPS_ENT));

endmodule

// File: rtl/clk_lane_ovr.sv
module clk_lane_ovr (
    input  logic sel,
    input  logic val,
    input  logic fsm_en,
    output logic en
);
    assign en = sel ? val : fsm_en;
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
    import clk_lane_pkg::*;
#(
    parameter int W = TIM_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hs_req,
    input  logic           ulps_req,
    input  logic           ana_ready,
    input  logic [4*W-1:0] lane_tim,
    input  logic [W-1:0]   lpx_cyc,
    input  logic [W-1:0]   pre_cyc,
    input  logic           hs_ovr_sel,
    input  logic           hs_ovr_val,
    input  logic           lp_ovr_sel,
    input  logic           lp_ovr_val,
    output logic           tx_hs_en,
    output logic           tx_lp_en,
    output logic           lp_dp,
    output logic           lp_dn,
    output logic           hs_clk_run,
    output logic           hs_ack,
    output logic [3:0]     lane_status
);
    localparam int N_OVR = 2;

    lane_state_e state;
    lane_drive_t drv;
    logic        rdy_q;
    logic [N_OVR-1:0] o_sel, o_val, o_fsm, o_en;

    clk_lane_fsm #(.W(W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hs_req   (hs_req),
        .ulps_req (ulps_req),
        .tim      (lane_tim_t'(lane_tim)),
        .lpx_cyc  (lpx_cyc),
        .pre_cyc  (pre_cyc),
        .state    (state),
        .drv      (drv)
    );

    // Index 0: HS enable, index 1: LP enable.
    assign o_sel = {lp_ovr_sel, hs_ovr_sel};
    assign o_val = {lp_ovr_val, hs_ovr_val};
    assign o_fsm = {drv.lp_en, drv.hs_en};

    for (genvar i = 0; i < N_OVR; i++) begin : g_ovr
        clk_lane_ovr u_ovr (
            .sel    (o_sel[i]),
            .val    (o_val[i]),
            .fsm_en (o_fsm[i]),
            .en     (o_en[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= ana_ready;
    end

    assign tx_hs_en    = o_en[0];
    assign tx_lp_en    = o_en[1];
    assign lp_dp       = drv.dp;
    assign lp_dn       = drv.dn;
    assign hs_clk_run  = drv.clk_run;
    assign hs_ack      = drv.ack;
    assign lane_status = {rdy_q, state == ST_STOP, state == ST_ULPS, drv.clk_run};

    // R3
    ack_with_clock_chk: assert property (@(posedge clk) disable iff (rst)
        hs_ack |-> hs_clk_run);

    // R11
    ready_delay_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (lane_status[3] == $past(ana_ready)));

endmodule

// File: tb/clk_lane_seq_bench.sv
module clk_lane_seq_bench;

    localparam int C_STOP = 0, C_LP01 = 1, C_PREP = 2, C_ZERO = 3, C_PRE = 4,
                   C_RUN = 5, C_POST = 6, C_TRAIL = 7, C_LP10 = 8, C_ULPS = 9;
    localparam int M_IDLE = 0, M_HOLD = 1, M_ULPW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, hs_req, ulps_req, ana_ready;
    logic [31:0] lane_tim;
    logic [7:0] lpx_cyc, pre_cyc;
    logic hs_ovr_sel, hs_ovr_val, lp_ovr_sel, lp_ovr_val;
    logic tx_hs_en, tx_lp_en, lp_dp, lp_dn, hs_clk_run, hs_ack;
    logic [3:0] lane_status;

    clk_lane_seq u_clk_lane_seq (
        .clk(clk), .rst(rst), .hs_req(hs_req), .ulps_req(ulps_req),
        .ana_ready(ana_ready), .lane_tim(lane_tim), .lpx_cyc(lpx_cyc),
        .pre_cyc(pre_cyc), .hs_ovr_sel(hs_ovr_sel), .hs_ovr_val(hs_ovr_val),
        .lp_ovr_sel(lp_ovr_sel), .lp_ovr_val(lp_ovr_val),
        .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .lp_dp(lp_dp), .lp_dn(lp_dn),
        .hs_clk_run(hs_clk_run), .hs_ack(hs_ack), .lane_status(lane_status)
    );

    int n_vec = 0, n_bad = 0, cyc = 0;
    int q[$];
    int mode = M_IDLE;
    int code = C_STOP;
    logic exp_rdy = 1'b0;
    bit done_flag = 0;

    // R5: zero count lasts one cycle
    function automatic int span(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic push(input int c, input int n);
        for (int i = 0; i < n; i++) q.push_back(c);
    endtask

    function automatic string tag_of(input int c);
        case (c)
            C_STOP: return "R1";
            C_LP01, C_PREP, C_ZERO, C_PRE: return "R2";
            C_RUN: return "R3";
            C_POST, C_TRAIL: return "R4";
            default: return "R9";
        endcase
    endfunction

    // {lp_en, hs_en, dp, dn, clk_run, ack}
    function automatic logic [5:0] drive_of(input int c);
        case (c)
            C_STOP:  return 6'b101100;
            C_LP01:  return 6'b100100;
            C_PREP:  return 6'b100000;
            C_ZERO:  return 6'b010000;
            C_PRE:   return 6'b010010;
            C_RUN:   return 6'b010011;
            C_POST:  return 6'b010010;
            C_TRAIL: return 6'b010000;
            C_LP10:  return 6'b101000;
            default: return 6'b100000;
        endcase
    endfunction

    // R6: prepare [31:24], zero [23:16], post [15:8], trail [7:0]
    task automatic decide();
        case (mode)
            M_IDLE: begin
                if (hs_req) begin
                    push(C_LP01, span(lpx_cyc));
                    push(C_PREP, span(lane_tim[31:24]));
                    push(C_ZERO, span(lane_tim[23:16]));
                    push(C_PRE,  span(pre_cyc));
                    mode = M_HOLD;
                end else if (ulps_req) begin
                    push(C_LP10, span(lpx_cyc));
                    push(C_ULPS, 1);
                    mode = M_ULPW;
                end else push(C_STOP, 1);
            end
            M_HOLD: begin
                if (hs_req) push(C_RUN, 1);
                else begin
                    push(C_POST,  span(lane_tim[15:8]));
                    push(C_TRAIL, span(lane_tim[7:0]));
                    push(C_STOP, 1);
                    mode = M_IDLE;
                end
            end
            default: begin
                if (ulps_req) push(C_ULPS, 1);
                else begin
                    push(C_LP10, span(lpx_cyc));
                    push(C_STOP, 1);
                    mode = M_IDLE;
                end
            end
        endcase
    endtask

    always @(posedge clk) begin
        logic [5:0] d;
        logic [9:0] e, a;
        string t;
        #1;
        if (!done_flag) begin
            cyc++;
            if (rst) begin
                q.delete();
                mode = M_IDLE;
                code = C_STOP;
                exp_rdy = 1'b0;
            end else begin
                exp_rdy = ana_ready;
                if (q.size() == 0) decide();
                code = q.pop_front();
            end
            d = drive_of(code);
            if (lp_ovr_sel) d[5] = lp_ovr_val;
            if (hs_ovr_sel) d[4] = hs_ovr_val;
            e = {d, exp_rdy, code == C_STOP, code == C_ULPS, drive_of(code)[1]};
            a = {tx_lp_en, tx_hs_en, lp_dp, lp_dn, hs_clk_run, hs_ack, lane_status};
            n_vec++;
            if (a !== e) begin
                n_bad++;
                if ((a[9:8] !== e[9:8]) && (lp_ovr_sel || hs_ovr_sel)) t = "R7";
                else if (a[9:4] === e[9:4] && a[3] !== e[3]) t = "R11";
                else if (a[9:4] === e[9:4]) t = "R8";
                else t = tag_of(code);
                $display("FAIL %s cycle %0d: got %b expected %b", t, cyc, a, e);
            end
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ack();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (hs_ack) break;
        end
    endtask

    task automatic wait_stop();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (lane_status[2] && q.size() == 0) break;
        end
    endtask

    initial begin
        rst = 1'b1; hs_req = 0; ulps_req = 0; ana_ready = 0;
        lane_tim = 32'h0; lpx_cyc = 0; pre_cyc = 0;
        hs_ovr_sel = 0; hs_ovr_val = 0; lp_ovr_sel = 0; lp_ovr_val = 0;
        tick(4);                                  // R1 reset state
        rst = 1'b0;
        tick(2);
        ana_ready = 1; tick(1); ana_ready = 0; tick(1); ana_ready = 1; tick(2); // R11

        // R2 R3 R4 R6: distinct counts per field
        lane_tim = {8'd2, 8'd4, 8'd5, 8'd3}; lpx_cyc = 8'd3; pre_cyc = 8'd6;
        hs_req = 1; wait_ack(); tick(10);
        hs_req = 0; wait_stop(); tick(2);

        // R5: all counts zero
        lane_tim = 32'h0; lpx_cyc = 0; pre_cyc = 0;
        hs_req = 1; wait_ack(); tick(3);
        hs_req = 0; wait_stop(); tick(2);

        // R10: request dropped before the acknowledge
        lane_tim = {8'd1, 8'd2, 8'd3, 8'd1}; lpx_cyc = 8'd2; pre_cyc = 8'd4;
        hs_req = 1; tick(1); hs_req = 0; wait_stop(); tick(3);

        // R9: ultra-low-power entry and exit, then priority of hs_req
        ulps_req = 1; tick(12); ulps_req = 0; wait_stop(); tick(2);
        ulps_req = 1; hs_req = 1; wait_ack(); ulps_req = 0; tick(3);

        // R7 R8: overrides during clocking and in stop
        hs_ovr_sel = 1; hs_ovr_val = 0; tick(3);
        lp_ovr_sel = 1; lp_ovr_val = 1; tick(3);
        hs_ovr_sel = 0; lp_ovr_sel = 0;
        hs_req = 0; wait_stop();
        hs_ovr_sel = 1; hs_ovr_val = 1; lp_ovr_sel = 1; lp_ovr_val = 0; tick(4);
        hs_ovr_sel = 0; lp_ovr_sel = 0; tick(2);

        // long counts at the top of the range
        lane_tim = {8'd255, 8'd7, 8'd200, 8'd9}; lpx_cyc = 8'd255; pre_cyc = 8'd1;
        hs_req = 1; wait_ack(); tick(2); hs_req = 0; wait_stop(); tick(3);

        // reset in the middle of a sequence returns to stop (R1)
        lane_tim = {8'd5, 8'd5, 8'd5, 8'd5}; lpx_cyc = 8'd5; pre_cyc = 8'd5;
        hs_req = 1; tick(8); rst = 1; hs_req = 0; tick(2); rst = 0; tick(4);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule